// File: doc/BRIEF.md
# Banked General-Purpose Register File with Shadow Sets

This block is the integer register storage of a processor core. It holds a base bank of thirty-two 32-bit registers plus a configurable number of shadow banks, each a full copy of the same index space. A current-set field, held inside the block, picks the bank that serves every ordinary operand access. Two read ports and one write port serve normal instructions. A separate cross-bank read and cross-bank write pair lets kernel code reach a bank other than the active one, for example to save or restore a context, without moving the current-set field.

Beside the general-purpose banks sits a small control-register bank. Writes to it are accepted only in supervisor mode. In user mode a control-register write is silently dropped.

All reads are combinational and all writes land on the rising clock edge. A read of the register being written in the same cycle sees the new value. Every port is a plain level signal with no handshake, because an access always completes in its own cycle and never stalls.

Top module: `banked_regfile`

## Requirements
- R1: There are NUM_SHADOW+1 banks (default 4), each with 32 registers of 32 bits. When `wr_en` is high, `wr_data` is stored on the rising edge into register `wr_idx` of the active bank, and later reads of that register on `rd_a` or `rd_b` return it.
- R2: Register 0 reads as zero in every bank, through all read ports. Normal and cross-bank writes to index 0 are ignored.
- R3: The current-set field resets to 0. When `set_load` is high, `set_val` is stored on the rising edge. `active_set` shows the stored value, and the new set governs operand accesses from the next cycle on.
- R4: A write into one bank leaves the registers of every other bank unchanged.
- R5: `xr_data` returns register `xr_idx` of bank `xr_bank`, combinationally. Cross-bank reads never change the current-set field.
- R6: When `xw_en` is high, `xw_data` is stored into register `xw_idx` of bank `xw_bank` on the rising edge. The current-set field and all other registers are unchanged.
- R7: A current-set value, `xr_bank` or `xw_bank` greater than NUM_SHADOW addresses bank 0.
- R8: A read on `rd_a`, `rd_b` or `xr` of the same effective bank and index that a normal or cross-bank write targets in that cycle returns the written data.
- R9: If a normal write and a cross-bank write hit the same bank and index in one cycle, the normal write's data is stored, and is the value bypassed to reads.
- R10: The control bank has CTL_REGS registers (default 16). When `cw_en` is high and `user_mode` is 0, `cw_data` is stored into `cw_idx` on the rising edge. `cr_data` returns register `cr_idx`, with write-first bypass. An index of CTL_REGS or more reads as 0, and writes to it are ignored.
- R11: When `user_mode` is 1, a control-register write has no effect. It is neither stored nor bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| user_mode | input | 1 | 1 = user mode, 0 = supervisor mode |
| set_load | input | 1 | Load the current-set field |
| set_val | input | 6 | New current-set value |
| active_set | output | 6 | Stored current-set field |
| rd_a_idx | input | 5 | Operand A register index |
| rd_a_data | output | 32 | Operand A value |
| rd_b_idx | input | 5 | Operand B register index |
| rd_b_data | output | 32 | Operand B value |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 5 | Normal write index |
| wr_data | input | 32 | Normal write data |
| xr_bank | input | 6 | Cross-bank read bank |
| xr_idx | input | 5 | Cross-bank read index |
| xr_data | output | 32 | Cross-bank read value |
| xw_en | input | 1 | Cross-bank write enable |
| xw_bank | input | 6 | Cross-bank write bank |
| xw_idx | input | 5 | Cross-bank write index |
| xw_data | input | 32 | Cross-bank write data |
| cr_idx | input | 5 | Control-register read index |
| cr_data | output | 32 | Control-register read value |
| cw_en | input | 1 | Control-register write enable |
| cw_idx | input | 5 | Control-register write index |
| cw_data | input | 32 | Control-register write data |

## Verification
Each bank is first filled with a pattern that encodes both the bank and the index, and is then read back bank by bank. A value in the wrong bank, or a write that leaked into another bank, shows up as a wrong pattern. Directed passes target the cross-bank ports while a different set is active, out-of-range set values, index 0 and same-cycle collisions, so that the bypass and priority paths are told apart from plain storage. A long random mix then varies all ports together, including mode changes and set changes, against a behavioural model compared every cycle.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int XLEN       = 32;
  localparam int NREG       = 32;
  localparam int IDX_W      = $clog2(NREG);
  localparam int SET_W      = 6;
  localparam int MAX_SHADOW = (1 << SET_W) - 1;

  typedef logic [XLEN-1:0]  word_t;
  typedef logic [IDX_W-1:0] ridx_t;
  typedef logic [SET_W-1:0] setf_t;
endpackage

// File: rtl/rf_bank_map.sv
// Maps a raw set number onto a physical bank; values beyond the
// configured shadow count fall back to the base bank.
module rf_bank_map
  import rf_pkg::*;
#(
  parameter int NUM_SHADOW = 3,
  parameter int BANK_W     = 2
) (
  input  setf_t             raw,
  output logic [BANK_W-1:0] bank
);
  localparam setf_t LIMIT = setf_t'(NUM_SHADOW);

  always_comb begin
    if (raw > LIMIT) bank = '0;
    else             bank = raw[BANK_W-1:0];
  end
endmodule

// File: rtl/rf_gpr_store.sv
// Multi-bank general-purpose storage: two write ports (normal, cross-bank),
// N_RD combinational read ports with write-first bypass.
module rf_gpr_store
  import rf_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int N_RD      = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         nw_en,
  input  logic [BANK_W-1:0]            nw_bank,
  input  ridx_t                        nw_idx,
  input  word_t                        nw_data,
  input  logic                         cw_en,
  input  logic [BANK_W-1:0]            cw_bank,
  input  ridx_t                        cw_idx,
  input  word_t                        cw_data,
  input  logic [N_RD-1:0][BANK_W-1:0]  rd_bank,
  input  logic [N_RD-1:0][IDX_W-1:0]   rd_idx,
  output logic [N_RD-1:0][XLEN-1:0]    rd_data
);
  word_t mem [NUM_BANKS][NREG];

  logic nw_live, cw_live, same_target;
  assign nw_live     = nw_en && (nw_idx != '0);
  assign cw_live     = cw_en && (cw_idx != '0);
  assign same_target = (nw_bank == cw_bank) && (nw_idx == cw_idx);

  // Cross-bank write first so the normal write wins on a collision.
  always_ff @(posedge clk) begin
    if (cw_live) mem[cw_bank][cw_idx] <= cw_data;
    if (nw_live) mem[nw_bank][nw_idx] <= nw_data;
  end

  for (genvar p = 0; p < N_RD; p++) begin : g_rd
    logic n_hit, c_hit;
    assign n_hit = nw_live && (nw_bank == rd_bank[p]) && (nw_idx == rd_idx[p]);
    assign c_hit = cw_live && (cw_bank == rd_bank[p]) && (cw_idx == rd_idx[p]);
    always_comb begin
      if (rd_idx[p] == '0) rd_data[p] = '0;
      else if (n_hit)      rd_data[p] = nw_data;
      else if (c_hit)      rd_data[p] = cw_data;
      else                 rd_data[p] = mem[rd_bank[p]][rd_idx[p]];
    end
  end

  AST_NORMAL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    nw_live |=> mem[$past(nw_bank)][$past(nw_idx)] == $past(nw_data)); // R1

  AST_CROSS_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_live && !(nw_live && same_target))
      |=> mem[$past(cw_bank)][$past(cw_idx)] == $past(cw_data)); // R6

  AST_COLLISION_NORMAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_live && nw_live && same_target)
      |=> mem[$past(cw_bank)][$past(cw_idx)] == $past(nw_data)); // R9
endmodule

// File: rtl/rf_ctl_bank.sv
// Control-register bank; writes accepted only outside user mode.
module rf_ctl_bank
  import rf_pkg::*;
#(
  parameter int CTL_REGS = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  user_mode,
  input  logic  wr_en,
  input  ridx_t wr_idx,
  input  word_t wr_data,
  input  ridx_t rd_idx,
  output word_t rd_data
);
  localparam int CIDX_W = $clog2(CTL_REGS);
  localparam logic [IDX_W:0] LIMIT = (IDX_W+1)'(CTL_REGS);

  logic [CTL_REGS-1:0][XLEN-1:0] regs_q;
  logic wr_ok, rd_ok, hit;

  assign wr_ok = wr_en && !user_mode && ({1'b0, wr_idx} < LIMIT);
  assign rd_ok = {1'b0, rd_idx} < LIMIT;
  assign hit   = wr_ok && (wr_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (wr_ok) regs_q[wr_idx[CIDX_W-1:0]] <= wr_data;
  end

  always_comb begin
    if (!rd_ok)  rd_data = '0;
    else if (hit) rd_data = wr_data;
    else          rd_data = regs_q[rd_idx[CIDX_W-1:0]];
  end

  AST_USER_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && user_mode) |=> $stable(regs_q)); // R11

  AST_SUPERVISOR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> regs_q[$past(wr_idx[CIDX_W-1:0])] == $past(wr_data)); // R10
endmodule

// File: rtl/banked_regfile.sv
// Banked integer register file with shadow sets, cross-bank move ports
// and a mode-protected control bank. NUM_SHADOW may range 0..63.
module banked_regfile
  import rf_pkg::*;
#(
  parameter int NUM_SHADOW = 3,
  parameter int CTL_REGS   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        user_mode,
  input  logic        set_load,
  input  logic [5:0]  set_val,
  output logic [5:0]  active_set,
  input  logic [4:0]  rd_a_idx,
  output logic [31:0] rd_a_data,
  input  logic [4:0]  rd_b_idx,
  output logic [31:0] rd_b_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [31:0] wr_data,
  input  logic [5:0]  xr_bank,
  input  logic [4:0]  xr_idx,
  output logic [31:0] xr_data,
  input  logic        xw_en,
  input  logic [5:0]  xw_bank,
  input  logic [4:0]  xw_idx,
  input  logic [31:0] xw_data,
  input  logic [4:0]  cr_idx,
  output logic [31:0] cr_data,
  input  logic        cw_en,
  input  logic [4:0]  cw_idx,
  input  logic [31:0] cw_data
);
  localparam int NUM_BANKS = NUM_SHADOW + 1;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int N_MAP     = 3;  // 0: current set, 1: cross read, 2: cross write
  localparam int N_RD      = 3;  // 0: operand A, 1: operand B, 2: cross read

  setf_t set_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        set_q <= '0;
    else if (set_load) set_q <= set_val;
  end
  assign active_set = set_q;

  setf_t [N_MAP-1:0]             raw_sel;
  logic  [N_MAP-1:0][BANK_W-1:0] eff_bank;

  assign raw_sel[0] = set_q;
  assign raw_sel[1] = xr_bank;
  assign raw_sel[2] = xw_bank;

  for (genvar m = 0; m < N_MAP; m++) begin : g_map
    rf_bank_map #(.NUM_SHADOW(NUM_SHADOW), .BANK_W(BANK_W)) i_map (
      .raw  (raw_sel[m]),
      .bank (eff_bank[m])
    );
  end

  logic [N_RD-1:0][BANK_W-1:0] rd_bank;
  logic [N_RD-1:0][IDX_W-1:0]  rd_idx;
  logic [N_RD-1:0][XLEN-1:0]   rd_data;

  assign rd_bank[0] = eff_bank[0];
  assign rd_bank[1] = eff_bank[0];
  assign rd_bank[2] = eff_bank[1];
  assign rd_idx[0]  = rd_a_idx;
  assign rd_idx[1]  = rd_b_idx;
  assign rd_idx[2]  = xr_idx;

  rf_gpr_store #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .N_RD(N_RD)) i_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .nw_en   (wr_en),
    .nw_bank (eff_bank[0]),
    .nw_idx  (wr_idx),
    .nw_data (wr_data),
    .cw_en   (xw_en),
    .cw_bank (eff_bank[2]),
    .cw_idx  (xw_idx),
    .cw_data (xw_data),
    .rd_bank (rd_bank),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign xr_data   = rd_data[2];

  rf_ctl_bank #(.CTL_REGS(CTL_REGS)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .user_mode (user_mode),
    .wr_en     (cw_en),
    .wr_idx    (cw_idx),
    .wr_data   (cw_data),
    .rd_idx    (cr_idx),
    .rd_data   (cr_data)
  );

  AST_SET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !set_load |=> $stable(active_set)); // R3

  AST_SET_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    set_load |=> active_set == $past(set_val)); // R3

  AST_CROSS_OPS_KEEP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((xw_en || xr_idx != '0) && !set_load) |=> active_set == $past(active_set)); // R5
endmodule

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
  localparam int NS = 3;
  localparam int NB = NS + 1;
  localparam int CR = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic        rst_n, user_mode, set_load, wr_en, xw_en, cw_en;
  logic [5:0]  set_val, active_set, xr_bank, xw_bank;
  logic [4:0]  rd_a_idx, rd_b_idx, wr_idx, xr_idx, xw_idx, cr_idx, cw_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, xr_data, xw_data, cr_data, cw_data;

  banked_regfile #(.NUM_SHADOW(NS), .CTL_REGS(CR)) i_banked_regfile (
    .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
    .set_load(set_load), .set_val(set_val), .active_set(active_set),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .xr_bank(xr_bank), .xr_idx(xr_idx), .xr_data(xr_data),
    .xw_en(xw_en), .xw_bank(xw_bank), .xw_idx(xw_idx), .xw_data(xw_data),
    .cr_idx(cr_idx), .cr_data(cr_data),
    .cw_en(cw_en), .cw_idx(cw_idx), .cw_data(cw_data)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference model
  bit [31:0] g_val [NB][32];
  bit        g_known [NB][32];
  bit [31:0] c_val [CR];
  bit        c_known [CR];
  int        set_raw = 0;

  function automatic int eff(int raw);
    return (raw > NS) ? 0 : raw;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic bit exp_gpr(int b, int idx, output logic [31:0] v, output string tag);
    bit nh, xh;
    v = '0;
    if (idx == 0) begin tag = "R2"; return 1'b1; end
    nh = wr_en && (idx == int'(wr_idx)) && (b == eff(int'(set_raw)));
    xh = xw_en && (idx == int'(xw_idx)) && (b == eff(int'(xw_bank)));
    if (nh) begin v = wr_data; tag = xh ? "R9" : "R8"; return 1'b1; end
    if (xh) begin v = xw_data; tag = "R8"; return 1'b1; end
    v = g_val[b][idx];
    tag = "R1";
    return g_known[b][idx];
  endfunction

  task automatic compare();
    logic [31:0] v;
    string t;
    chk("R3 active_set", {26'd0, active_set}, 32'(set_raw));
    if (exp_gpr(eff(set_raw), int'(rd_a_idx), v, t)) chk({t, " rd_a"}, rd_a_data, v);
    if (exp_gpr(eff(set_raw), int'(rd_b_idx), v, t)) chk({t, " rd_b"}, rd_b_data, v);
    if (exp_gpr(eff(int'(xr_bank)), int'(xr_idx), v, t)) begin
      if (int'(xr_bank) > NS) t = "R7";
      else if (t == "R1") t = "R5";
      chk({t, " xr"}, xr_data, v);
    end
    if (int'(cr_idx) >= CR) chk("R10 ctl out of range", cr_data, 32'd0);
    else if (cw_en && cw_idx == cr_idx && !user_mode) chk("R10 ctl bypass", cr_data, cw_data);
    else if (c_known[cr_idx]) begin
      if (cw_en && user_mode) chk("R11 ctl user write", cr_data, c_val[cr_idx]);
      else chk("R10 ctl read", cr_data, c_val[cr_idx]);
    end
  endtask

  task automatic commit();
    if (xw_en && xw_idx != 0) begin
      g_val[eff(int'(xw_bank))][xw_idx] = xw_data;
      g_known[eff(int'(xw_bank))][xw_idx] = 1'b1;
    end
    if (wr_en && wr_idx != 0) begin
      g_val[eff(set_raw)][wr_idx] = wr_data;
      g_known[eff(set_raw)][wr_idx] = 1'b1;
    end
    if (cw_en && !user_mode && int'(cw_idx) < CR) begin
      c_val[cw_idx] = cw_data;
      c_known[cw_idx] = 1'b1;
    end
    if (set_load) set_raw = int'(set_val);
  endtask

  // Inputs are driven just after a falling edge; outputs checked mid low phase.
  task automatic step();
    #5;
    compare();
    @(posedge clk);
    commit();
    @(negedge clk);
  endtask

  task automatic idle();
    user_mode = 0; set_load = 0; set_val = 0;
    rd_a_idx = 0; rd_b_idx = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    xr_bank = 0; xr_idx = 0; xw_en = 0; xw_bank = 0; xw_idx = 0; xw_data = 0;
    cr_idx = 0; cw_en = 0; cw_idx = 0; cw_data = 0;
  endtask

  task automatic load_set(int s);
    idle(); set_load = 1; set_val = 6'(s); step(); idle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3: reset value of the current-set field
    chk("R3 reset active_set", {26'd0, active_set}, 32'd0);

    // R1/R2/R8: fill each bank with a bank+index pattern, bypassing on port A
    for (int b = 0; b < NB; b++) begin
      load_set(b);
      for (int i = 0; i < 32; i++) begin
        wr_en = 1; wr_idx = 5'(i); wr_data = 32'hB000_0000 | (b << 16) | i;
        rd_a_idx = 5'(i); rd_b_idx = 5'((i + 1) % 32);
        step();
      end
      idle();
    end

    // R4/R5: read every bank back, operand ports and cross-bank port
    for (int b = 0; b < NB; b++) begin
      load_set(b);
      for (int i = 0; i < 32; i++) begin
        rd_a_idx = 5'(i); rd_b_idx = 5'(31 - i);
        xr_bank = 6'((b + 1) % NB); xr_idx = 5'(i);
        step();
      end
      idle();
    end

    // R6: cross-bank write into bank 2 while bank 1 is active, then read back
    load_set(1);
    for (int i = 0; i < 32; i++) begin
      xw_en = 1; xw_bank = 6'd2; xw_idx = 5'(i); xw_data = 32'hC0DE_0000 | i;
      xr_bank = 6'd2; xr_idx = 5'(i); rd_a_idx = 5'(i);
      step();
    end
    idle();
    load_set(2);
    for (int i = 0; i < 32; i++) begin rd_a_idx = 5'(i); step(); end

    // R7: out-of-range set and cross-bank numbers address bank 0
    load_set(9);
    wr_en = 1; wr_idx = 5'd7; wr_data = 32'h7777_0007; step(); idle();
    load_set(0);
    rd_a_idx = 5'd7; xr_bank = 6'd63; xr_idx = 5'd7; step();
    xw_en = 1; xw_bank = 6'd40; xw_idx = 5'd8; xw_data = 32'h4040_0008; step(); idle();
    rd_a_idx = 5'd8; step();

    // R9: collision of normal and cross-bank writes
    load_set(3);
    wr_en = 1; wr_idx = 5'd12; wr_data = 32'h1111_1111;
    xw_en = 1; xw_bank = 6'd3; xw_idx = 5'd12; xw_data = 32'h2222_2222;
    rd_a_idx = 5'd12; xr_bank = 6'd3; xr_idx = 5'd12;
    step(); idle();
    rd_a_idx = 5'd12; step();

    // R10: supervisor writes to every control register and beyond
    for (int i = 0; i < 20; i++) begin
      cw_en = 1; cw_idx = 5'(i); cw_data = 32'hCC00_0000 | i; cr_idx = 5'(i);
      step();
    end
    idle();
    // R11: user-mode writes must leave the control bank untouched
    for (int i = 0; i < CR; i++) begin
      user_mode = 1; cw_en = 1; cw_idx = 5'(i); cw_data = 32'hDEAD_0000 | i; cr_idx = 5'(i);
      step();
      idle(); cr_idx = 5'(i); step();
    end

    // Random mix of all ports
    for (int n = 0; n < 4000; n++) begin
      user_mode = 1'($urandom);
      set_load  = ($urandom % 8) == 0; set_val = 6'($urandom % 7);
      rd_a_idx  = 5'($urandom); rd_b_idx = 5'($urandom);
      wr_en     = 1'($urandom); wr_idx = 5'($urandom % 8); wr_data = $urandom;
      xr_bank   = 6'($urandom % 6); xr_idx = 5'($urandom % 8);
      xw_en     = 1'($urandom); xw_bank = 6'($urandom % 6); xw_idx = 5'($urandom % 8);
      xw_data   = $urandom;
      cr_idx    = 5'($urandom % 20); cw_en = 1'($urandom);
      cw_idx    = 5'($urandom % 20); cw_data = $urandom;
      if (n % 3 == 0) rd_a_idx = wr_idx;
      step();
    end
    idle();

    done = 1;
    finish_run();
  end
endmodule